// File: doc/BRIEF.md
# 16-bit CRC Coprocessor with Selectable Preset

This block computes a 16-bit CRC over a stream of bytes, one byte per clock. A start pulse picks one of four fixed start values through a 2-bit selector, fixes the bit order for the run, and opens a valid/ready byte input. The run ends when a byte marked as last is accepted. The result is shown as a high byte and a low byte.

The generator polynomial is x^16 + x^12 + x^5 + 1. In the default order each byte is consumed least significant bit first, with the register shifting right and the reflected constant 0x8408 applied. In the alternative order each byte is consumed most significant bit first, with the register shifting left and 0x1021 applied. Each output byte is then bit-reversed. When the run ends a done flag rises and stays high, a one-cycle interrupt pulse is issued, and a zero flag reports whether the final 16-bit value is zero. A new start pulse at any time abandons the current run and reloads the start value.

Top module: `crc16_engine`

## Requirements
- R1: After reset, done_o, zero_o, irq_o and in_ready_o are 0, and both result bytes are 0x00.
- R2: A start pulse loads the register from preset_sel_i. The codes are 2'b00 = 0x0000, 2'b01 = 0x6363, 2'b10 = 0xA671 and 2'b11 = 0xFFFF. The loaded value appears on the result bytes in the cycle after start.
- R3: With msb_first_i = 0 at start, each byte is folded in bit 0 first, using a right shift and the constant 0x8408. The result bytes show register bits [15:8] and [7:0] unchanged. From 0x6363, the ASCII bytes "123456789" give 0xBF05. From 0xFFFF they give 0x6F91.
- R4: With msb_first_i = 1 at start, each byte is folded in bit 7 first, using a left shift and the constant 0x1021. Each result byte is the bit-reverse of its register byte. From 0xFFFF, "123456789" gives register 0x29B1, which shows as result_msb_o = 0x94 and result_lsb_o = 0x8D.
- R5: in_ready_o is 1 from the cycle after start until a byte with last_i = 1 is accepted. A byte is accepted only when valid_i and in_ready_o are both 1 and start_i is 0. Bytes offered while in_ready_o is 0 change nothing.
- R6: done_o rises in the cycle after the last byte is accepted and holds until the next start. irq_o is 1 for exactly that one cycle.
- R7: zero_o is 0 from the cycle after start until the run completes. It is then 1 exactly when the final 16-bit value is zero. A frame followed by its own LSB-first CRC (low byte first) gives zero_o = 1.
- R8: A start pulse during a run abandons the run and reloads the start value. If a byte is offered in the same cycle, start wins and the byte is dropped.
- R9: preset_sel_i and msb_first_i are sampled only at start. Changing them during a run has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or restart pulse |
| preset_sel_i | input | 2 | Start value code, sampled at start |
| msb_first_i | input | 1 | Bit order select, sampled at start |
| data_i | input | 8 | Input byte |
| valid_i | input | 1 | Byte offered |
| last_i | input | 1 | Offered byte ends the run |
| in_ready_o | output | 1 | Byte input open (run active) |
| result_msb_o | output | 8 | Result high byte (bit-reversed in MSB-first mode) |
| result_lsb_o | output | 8 | Result low byte (bit-reversed in MSB-first mode) |
| done_o | output | 1 | Run finished, result valid |
| zero_o | output | 1 | Finished result equals zero |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
The bench checks published check values in both bit orders. A design that shifted in the wrong direction, or left the output bytes unreversed, would report 0x29B1 where 0x948D is expected. It appends a frame's own CRC to drive the register to zero, so a zero flag tied to the wrong condition, or not cleared at start, shows up. It restarts a run with a byte offered in the same cycle, and changes the order and preset inputs in the middle of a run. A design that let the byte win or kept sampling those inputs would end on a different value. Idle bytes and toggles of the order and preset inputs outside a run show whether the register is really frozen. Every cycle, a behavioural model is compared on all outputs, so a lasting done flag or a stretched interrupt pulse is caught.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned NUM_PRESETS = 1 << SEL_W;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_BUSY = 1'b1
  } run_state_e;

  function automatic crc_t reflect_crc(input crc_t v);
    crc_t r;
    for (int i = 0; i < int'(CRC_W); i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  function automatic byte_t reflect_byte(input byte_t v);
    byte_t r;
    for (int i = 0; i < int'(BYTE_W); i++) r[i] = v[BYTE_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc16_preset_mux.sv
module crc16_preset_mux
  import crc16_pkg::*;
#(
  parameter crc_t PRESET0 = 16'h0000,
  parameter crc_t PRESET1 = 16'h6363,
  parameter crc_t PRESET2 = 16'hA671,
  parameter crc_t PRESET3 = 16'hFFFF
) (
  input  logic [SEL_W-1:0] sel_i,
  output crc_t             value_o
);
  crc_t table_w [NUM_PRESETS];

  assign table_w[0] = PRESET0;
  assign table_w[1] = PRESET1;
  assign table_w[2] = PRESET2;
  assign table_w[3] = PRESET3;

  assign value_o = table_w[sel_i];
endmodule

// File: rtl/crc16_byte_step.sv
module crc16_byte_step
  import crc16_pkg::*;
#(
  parameter crc_t POLY = 16'h1021
) (
  input  crc_t  crc_i,
  input  byte_t data_i,
  input  logic  msb_first_i,
  output crc_t  crc_o
);
  localparam crc_t POLY_REF = reflect_crc(POLY);

  crc_t lsb_chain [BYTE_W+1];
  crc_t msb_chain [BYTE_W+1];

  assign lsb_chain[0] = crc_i;
  assign msb_chain[0] = crc_i;

  for (genvar b = 0; b < int'(BYTE_W); b++) begin : g_bit
    logic fb_lsb, fb_msb;
    // reflected order consumes data bit 0 first
    assign fb_lsb = lsb_chain[b][0] ^ data_i[b];
    assign lsb_chain[b+1] = (lsb_chain[b] >> 1) ^ (fb_lsb ? POLY_REF : '0);
    // normal order consumes data bit 7 first
    assign fb_msb = msb_chain[b][CRC_W-1] ^ data_i[BYTE_W-1-b];
    assign msb_chain[b+1] = (msb_chain[b] << 1) ^ (fb_msb ? POLY : '0);
  end

  assign crc_o = msb_first_i ? msb_chain[BYTE_W] : lsb_chain[BYTE_W];
endmodule

// File: rtl/crc16_run_ctrl.sv
module crc16_run_ctrl
  import crc16_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic valid_i,
  input  logic last_i,
  output logic busy_o,
  output logic load_o,
  output logic take_o,
  output logic fin_o
);
  run_state_e state_q, state_d;

  assign busy_o = (state_q == RUN_BUSY);
  assign load_o = start_i;
  // start has priority over any byte in the same cycle
  assign take_o = busy_o && valid_i && !start_i;
  assign fin_o  = take_o && last_i;

  always_comb begin
    state_d = state_q;
    if (start_i)    state_d = RUN_BUSY;
    else if (fin_o) state_d = RUN_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RUN_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
#(
  parameter crc_t POLY = 16'h1021
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] preset_sel_i,
  input  logic             msb_first_i,
  input  logic [7:0]       data_i,
  input  logic             valid_i,
  input  logic             last_i,
  output logic             in_ready_o,
  output logic [7:0]       result_msb_o,
  output logic [7:0]       result_lsb_o,
  output logic             done_o,
  output logic             zero_o,
  output logic             irq_o
);
  localparam int unsigned HALF = CRC_W / 2;

  logic busy_w, load_w, take_w, fin_w;
  crc_t preset_w, next_w, crc_q;
  logic msb_q, done_q, zero_q, irq_q;

  crc16_run_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .valid_i (valid_i),
    .last_i  (last_i),
    .busy_o  (busy_w),
    .load_o  (load_w),
    .take_o  (take_w),
    .fin_o   (fin_w)
  );

  crc16_preset_mux u_preset (
    .sel_i   (preset_sel_i),
    .value_o (preset_w)
  );

  crc16_byte_step #(.POLY(POLY)) u_step (
    .crc_i       (crc_q),
    .data_i      (data_i),
    .msb_first_i (msb_q),
    .crc_o       (next_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q  <= '0;
      msb_q  <= 1'b0;
      done_q <= 1'b0;
      zero_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= fin_w;
      if (load_w) begin
        crc_q  <= preset_w;
        msb_q  <= msb_first_i;
        done_q <= 1'b0;
        zero_q <= 1'b0;
      end else if (take_w) begin
        crc_q <= next_w;
        if (fin_w) begin
          done_q <= 1'b1;
          zero_q <= (next_w == '0);
        end
      end
    end
  end

  // output bytes, bit-reversed per byte in MSB-first mode
  logic [HALF-1:0] hi_w, lo_w;
  assign hi_w = crc_q[CRC_W-1:HALF];
  assign lo_w = crc_q[HALF-1:0];

  for (genvar k = 0; k < int'(HALF); k++) begin : g_out
    assign result_msb_o[k] = msb_q ? hi_w[HALF-1-k] : hi_w[k];
    assign result_lsb_o[k] = msb_q ? lo_w[HALF-1-k] : lo_w[k];
  end

  assign in_ready_o = busy_w;
  assign done_o     = done_q;
  assign zero_o     = zero_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [1:0] preset_sel_i,
  input logic       msb_first_i,
  input logic       valid_i,
  input logic       last_i,
  input logic       in_ready_o,
  input logic [7:0] result_msb_o,
  input logic [7:0] result_lsb_o,
  input logic       done_o,
  input logic       zero_o,
  input logic       irq_o
);
  assert_start_opens_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> in_ready_o && !done_o && !zero_o);

  assert_preset_ones_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && preset_sel_i == 2'b11 |=> result_msb_o == 8'hFF && result_lsb_o == 8'hFF);

  assert_preset_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && preset_sel_i == 2'b00 |=> result_msb_o == 8'h00 && result_lsb_o == 8'h00);

  assert_last_closes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && valid_i && last_i && !start_i |=> done_o && irq_o && !in_ready_o);

  assert_irq_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_done_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  assert_zero_low_running_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !zero_o && !done_o);

  assert_frozen_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o && !start_i |=> $stable(result_msb_o) && $stable(result_lsb_o));

  assert_zero_matches_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> done_o && result_msb_o == 8'h00 && result_lsb_o == 8'h00);
endmodule

bind crc16_engine crc16_engine_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .preset_sel_i (preset_sel_i),
  .msb_first_i  (msb_first_i),
  .valid_i      (valid_i),
  .last_i       (last_i),
  .in_ready_o   (in_ready_o),
  .result_msb_o (result_msb_o),
  .result_lsb_o (result_lsb_o),
  .done_o       (done_o),
  .zero_o       (zero_o),
  .irq_o        (irq_o)
);

// File: tb/crc16_engine_tb_top.sv
module crc16_engine_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] preset_sel_i = 2'b00;
  logic       msb_first_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       valid_i = 1'b0;
  logic       last_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] result_msb_o, result_lsb_o;
  logic       done_o, zero_o, irq_o;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  crc16_engine dut_i (.*);

  // ---------------- behavioural reference ----------------
  logic [15:0] m_crc;
  bit m_busy, m_msb, m_done, m_zero, m_irq;

  function automatic logic [15:0] ref_byte(logic [15:0] c, logic [7:0] d, bit msb);
    logic [15:0] r = c;
    if (!msb) begin
      for (int i = 0; i < 8; i++) begin
        bit fb = r[0] ^ d[i];
        r = r >> 1;
        if (fb) r = r ^ 16'h8408;
      end
    end else begin
      for (int i = 7; i >= 0; i--) begin
        bit fb = r[15] ^ d[i];
        r = r << 1;
        if (fb) r = r ^ 16'h1021;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] rev8(logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [15:0] preset_of(logic [1:0] s);
    case (s)
      2'b00: return 16'h0000;
      2'b01: return 16'h6363;
      2'b10: return 16'hA671;
      default: return 16'hFFFF;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_crc = 16'h0; m_busy = 0; m_msb = 0; m_done = 0; m_zero = 0; m_irq = 0;
    end else begin
      m_irq = 0;
      if (start_i) begin
        m_crc = preset_of(preset_sel_i); m_msb = msb_first_i;
        m_busy = 1; m_done = 0; m_zero = 0;
      end else if (m_busy && valid_i) begin
        m_crc = ref_byte(m_crc, data_i, m_msb);
        if (last_i) begin
          m_busy = 0; m_done = 1; m_irq = 1; m_zero = (m_crc == 16'h0);
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R3 R4 R5 R6 R7)
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      logic [7:0] eh, el;
      eh = m_msb ? rev8(m_crc[15:8]) : m_crc[15:8];
      el = m_msb ? rev8(m_crc[7:0])  : m_crc[7:0];
      check("R3_R4 model result", {16'h0, result_msb_o, result_lsb_o}, {16'h0, eh, el});
      check("R5 model in_ready", {31'h0, in_ready_o}, {31'h0, m_busy});
      check("R6 model done/irq", {30'h0, done_o, irq_o}, {30'h0, m_done, m_irq});
      check("R7 model zero", {31'h0, zero_o}, {31'h0, m_zero});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(bit st, logic [1:0] sel, bit msb, logic [7:0] d, bit v, bit l);
    start_i = st; preset_sel_i = sel; msb_first_i = msb;
    data_i = d; valid_i = v; last_i = l;
    @(negedge clk_i);
  endtask

  task automatic idle();
    step(0, 2'b00, 0, 8'h00, 0, 0);
  endtask

  task automatic send_digits(logic [1:0] sel, bit msb, bit last_on_nine);
    step(1, sel, msb, 8'h00, 0, 0);
    for (int i = 0; i < 9; i++)
      step(0, sel, msb, 8'h31 + 8'(i), 1, last_on_nine && i == 8);
  endtask

  task automatic expect_result(string tag, logic [15:0] exp);
    check(tag, {16'h0, result_msb_o, result_lsb_o}, {16'h0, exp});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (50000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    check("R1 reset flags", {28'h0, done_o, zero_o, irq_o, in_ready_o}, 32'h0);
    expect_result("R1 reset result", 16'h0000);

    // R2: each preset, LSB order shows it unchanged
    for (int s = 0; s < 4; s++) begin
      step(1, 2'(s), 0, 8'h00, 0, 0);
      expect_result("R2 preset load", preset_of(2'(s)));
      check("R2 run open", {31'h0, in_ready_o}, 32'h1);
    end
    // R2 in MSB order: 0x6363 shows as 0xC6C6
    step(1, 2'b01, 1, 8'h00, 0, 0);
    expect_result("R2 preset msb view", 16'hC6C6);

    // R3 known check values
    send_digits(2'b01, 0, 1);
    expect_result("R3 check 6363", 16'hBF05);
    check("R6 done and irq", {30'h0, done_o, irq_o}, 32'h3);
    check("R5 closed after last", {31'h0, in_ready_o}, 32'h0);
    idle();
    check("R6 irq single cycle", {30'h0, done_o, irq_o}, 32'h2);
    check("R7 nonzero result", {31'h0, zero_o}, 32'h0);

    send_digits(2'b11, 0, 1);
    expect_result("R3 check ffff", 16'h6F91);
    idle();

    // R4 MSB order with reversed bytes
    send_digits(2'b11, 1, 1);
    expect_result("R4 check msb", 16'h948D);
    check("R4 done", {31'h0, done_o}, 32'h1);
    idle();

    // R5 bytes ignored while idle; mode/preset toggles ignored
    step(0, 2'b10, 1, 8'h5A, 1, 0);
    step(0, 2'b01, 0, 8'hA5, 1, 1);
    expect_result("R5 idle bytes ignored", 16'h948D);
    check("R5 idle done kept", {31'h0, done_o}, 32'h1);

    // R7 frame plus its own CRC gives zero
    send_digits(2'b11, 0, 0);
    check("R7 zero low while running", {30'h0, zero_o, done_o}, 32'h0);
    step(0, 2'b11, 0, 8'h91, 1, 0);
    step(0, 2'b11, 0, 8'h6F, 1, 1);
    check("R7 zero flag set", {30'h0, zero_o, done_o}, 32'h3);
    expect_result("R7 zero result", 16'h0000);
    idle();

    // R8 abort: start with byte in same cycle, byte dropped
    step(1, 2'b00, 0, 8'h00, 0, 0);
    step(0, 2'b00, 0, 8'h77, 1, 0);
    step(1, 2'b01, 0, 8'hEE, 1, 0);
    expect_result("R8 abort reload", 16'h6363);
    for (int i = 0; i < 9; i++)
      step(0, 2'b01, 0, 8'h31 + 8'(i), 1, i == 8);
    expect_result("R8 after restart", 16'hBF05);
    idle();

    // R9 inputs changed mid-run have no effect
    step(1, 2'b11, 1, 8'h00, 0, 0);
    for (int i = 0; i < 9; i++)
      step(0, 2'(i), i[0], 8'h31 + 8'(i), 1, i == 8);
    expect_result("R9 sampled at start", 16'h948D);
    idle();

    // R5 valid gaps stall the run
    step(1, 2'b01, 0, 8'h00, 0, 0);
    for (int i = 0; i < 9; i++) begin
      step(0, 2'b01, 0, 8'hFF, 0, 1);
      step(0, 2'b01, 0, 8'h31 + 8'(i), 1, i == 8);
    end
    expect_result("R5 gaps ignored", 16'hBF05);
    idle();
    idle();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule